// File: doc/BRIEF.md
# Interrupt Flag and Status Unit for a Time-of-Day Clock

This unit gathers three single-cycle event pulses from a time-of-day clock core (a periodic tick, an alarm match and the end of a time update) and holds each one in a sticky flag. It builds the status byte that the host reads, combines the flags with their enable bits into a summary interrupt bit, and drives an active-low interrupt line.

The host reads the status byte by raising a one-cycle read strobe. The byte on `stat_o` in that cycle is the value the host takes. At the next clock edge every flag clears, apart from any flag whose event arrives in the same cycle as the read. A flag records its event even while its enable is off, so software can poll the flags without taking interrupts. Only the summary bit and the interrupt line pay attention to the enables.

All pins are plain control and status signals. The read strobe has no handshake and cannot be refused, so there is no back-pressure anywhere on this unit.

Top module: `intflag_status`

## Requirements
- R1: The status byte carries the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. Bits 3 to 0 always read 0.
- R2: A one-cycle event pulse sets its flag at the next clock edge, whatever the state of its enable.
- R3: Status bit 7 is 1 exactly when some flag is 1 and its enable is 1. The enables are `en_i[2]` for periodic, `en_i[1]` for alarm and `en_i[0]` for update-ended. Bit 7 follows a change on `en_i` in the same cycle.
- R4: A read strobe with no event in the same cycle returns the current byte and clears the whole byte from the next cycle on.
- R5: An event that coincides with a read strobe leaves its flag set after that read, so the next read reports it.
- R6: `irq_no` is low exactly when status bit 7 is 1.
- R7: Reset clears every flag and holds `irq_no` high.
- R8: Without a read strobe, a set flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prd_evt_i | input | 1 | Periodic event pulse |
| alm_evt_i | input | 1 | Alarm event pulse |
| upd_evt_i | input | 1 | Update-ended event pulse |
| en_i | input | 3 | Interrupt enables: [2] periodic, [1] alarm, [0] update-ended |
| stat_rd_i | input | 1 | One-cycle strobe: the host reads the status byte |
| stat_o | output | 8 | Status byte |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The hardest case to bring about is an event that lands in the same cycle as a clearing read, because a flag can be lost there. The bench creates it on purpose with a scripted read that carries a periodic pulse. Pseudo-random stretches then draw events, reads and enable changes at high rates, so coinciding reads, pulses on two sources at once and enable toggles on live flags all occur many times. A behavioural model is compared with the outputs on every cycle.

// File: rtl/intflag_pkg.sv
package intflag_pkg;
  localparam int unsigned NUM_SRC  = 3;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned SUM_BIT  = STAT_W - 1;
  typedef enum logic [1:0] {SRC_UPD = 2'd0, SRC_ALM = 2'd1, SRC_PRD = 2'd2} src_e;
  typedef logic [NUM_SRC-1:0] srcvec_t;
endpackage

// File: rtl/intflag_cell.sv
module intflag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (evt_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/intflag_summary.sv
module intflag_summary
  import intflag_pkg::*;
(
  input  srcvec_t flags_i,
  input  srcvec_t en_i,
  output logic    any_o
);
  assign any_o = |(flags_i & en_i);
endmodule

// File: rtl/intflag_status.sv
module intflag_status
  import intflag_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prd_evt_i,
  input  logic                 alm_evt_i,
  input  logic                 upd_evt_i,
  input  logic [NUM_SRC-1:0]   en_i,
  input  logic                 stat_rd_i,
  output logic [STAT_W-1:0]    stat_o,
  output logic                 irq_no
);
  srcvec_t evt;
  srcvec_t flags;
  logic    summary;

  always_comb begin
    evt          = '0;
    evt[SRC_PRD] = prd_evt_i;
    evt[SRC_ALM] = alm_evt_i;
    evt[SRC_UPD] = upd_evt_i;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
    intflag_cell i_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[g]),
      .clr_i  (stat_rd_i),
      .flag_o (flags[g])
    );
  end

  intflag_summary i_sum (
    .flags_i (flags),
    .en_i    (en_i),
    .any_o   (summary)
  );

  always_comb begin
    stat_o                                = '0;
    stat_o[FLAG_LSB +: NUM_SRC]           = flags;
    stat_o[SUM_BIT]                       = summary;
  end

  assign irq_no = ~summary;
endmodule

// File: rtl/intflag_status_chk.sv
module intflag_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prd_evt_i,
  input logic       alm_evt_i,
  input logic       upd_evt_i,
  input logic [2:0] en_i,
  input logic       stat_rd_i,
  input logic [7:0] stat_o,
  input logic       irq_no
);
  logic [2:0] ev;
  assign ev = {prd_evt_i, alm_evt_i, upd_evt_i};

  a_r1_low_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3:0] == 4'h0);
  a_r2_event_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((stat_o[6:4] & $past(ev)) == $past(ev)));
  a_r3_summary_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[7] == |(stat_o[6:4] & en_i));
  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !(|ev)) |=> stat_o[6:4] == 3'b000);
  a_r6_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_no == !stat_o[7]);
  a_r7_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (stat_o == 8'h00 && irq_no));
  a_r8_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i |=> ((stat_o[6:4] & $past(stat_o[6:4])) == $past(stat_o[6:4])));
endmodule

bind intflag_status intflag_status_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prd_evt_i(prd_evt_i), .alm_evt_i(alm_evt_i),
  .upd_evt_i(upd_evt_i), .en_i(en_i), .stat_rd_i(stat_rd_i), .stat_o(stat_o),
  .irq_no(irq_no)
);

// File: tb/test_intflag_status.sv
module test_intflag_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prd = 1'b0, alm = 1'b0, upd = 1'b0, rd = 1'b0;
  logic [2:0] en = 3'b000;
  logic [7:0] stat;
  logic       irq_n;
  int vectors = 0, errors = 0;
  bit done = 1'b0;
  bit m_prd = 0, m_alm = 0, m_upd = 0;

  always #5 clk = ~clk;

  intflag_status i_intflag_status (
    .clk_i(clk), .rst_ni(rst_n), .prd_evt_i(prd), .alm_evt_i(alm), .upd_evt_i(upd),
    .en_i(en), .stat_rd_i(rd), .stat_o(stat), .irq_no(irq_n)
  );

  // Behavioural reference: sticky flags, events win over a read
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prd = 0; m_alm = 0; m_upd = 0;
    end else begin
      m_prd = prd || (m_prd && !rd);
      m_alm = alm || (m_alm && !rd);
      m_upd = upd || (m_upd && !rd);
    end
  end

  function automatic logic [7:0] model_stat();
    bit sum;
    sum = (m_prd && en[2]) || (m_alm && en[1]) || (m_upd && en[0]);
    return {sum, m_prd, m_alm, m_upd, 4'b0000};
  endfunction

  task automatic cmp_model(string tag);
    logic [7:0] exp_s;
    exp_s = model_stat();
    vectors++;
    if (stat !== exp_s) begin
      errors++;
      $display("FAIL %s: stat_o=%02h expected %02h", tag, stat, exp_s);
    end
    vectors++;
    if (irq_n !== !exp_s[7]) begin
      errors++;
      $display("FAIL R6 (%s): irq_no=%b expected %b", tag, irq_n, !exp_s[7]);
    end
  endtask

  task automatic expect_lit(string tag, logic [7:0] es, logic ei);
    vectors++;
    if (stat !== es || irq_n !== ei) begin
      errors++;
      $display("FAIL %s: stat_o=%02h irq_no=%b expected %02h %b", tag, stat, irq_n, es, ei);
    end
  endtask

  // advance one cycle, then compare at the falling edge
  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    cmp_model(tag);
  endtask

  task automatic idle();
    prd = 0; alm = 0; upd = 0; rd = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    expect_lit("R7 during reset", 8'h00, 1'b1);
    rst_n = 1'b1;
    tick("R7");
    expect_lit("R7 after reset", 8'h00, 1'b1);

    // R2 / R1: alarm latches with its enable off
    alm = 1; tick("R2"); idle();
    expect_lit("R2 R1 alarm latched, enable off", 8'h20, 1'b1);
    tick("R8"); expect_lit("R8 alarm held", 8'h20, 1'b1);

    // R3 / R6: enabling alarm raises the summary in the same cycle
    en = 3'b010; #1; expect_lit("R3 R6 enable alarm", 8'hA0, 1'b0);
    en = 3'b101; #1; expect_lit("R3 other enables only", 8'h20, 1'b1);
    en = 3'b010;

    // R4: read returns the byte, then clears it
    @(negedge clk); rd = 1; #1; expect_lit("R4 read value", 8'hA0, 1'b0);
    tick("R4"); idle();
    expect_lit("R4 cleared after read", 8'h00, 1'b1);

    // R5: periodic event in the same cycle as a read of update flag
    upd = 1; tick("R2"); idle();
    expect_lit("R1 update flag bit 4", 8'h10, 1'b1);
    rd = 1; prd = 1; tick("R5"); idle();
    expect_lit("R5 periodic survives coincident read", 8'h40, 1'b1);
    en = 3'b100; #1; expect_lit("R5 R3 periodic enabled", 8'hC0, 1'b0);
    rd = 1; tick("R5"); idle();
    expect_lit("R5 reported then cleared", 8'h00, 1'b1);

    // all three at once
    prd = 1; alm = 1; upd = 1; en = 3'b001; tick("R2"); idle();
    expect_lit("R1 all flags", 8'hF0, 1'b0);

    // random stretch compared every cycle
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      prd = (lfsr[2:0] == 3'd0);
      alm = (lfsr[5:3] == 3'd1);
      upd = (lfsr[8:6] == 3'd2);
      rd  = (lfsr[11:9] < 3'd2);
      if (lfsr[15:13] == 3'd7) en = lfsr[2:0] ^ lfsr[12:10];
      #1; cmp_model("R3 random");
      tick("R2 R4 R5 R8 random");
    end
    idle();

    // R7: reset mid-run with flags set
    prd = 1; tick("R2"); idle();
    rst_n = 0; #1; expect_lit("R7 async reset", 8'h00, 1'b1);
    @(negedge clk); rst_n = 1;
    tick("R7"); expect_lit("R7 after second reset", 8'h00, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule